// File: doc/BRIEF.md
# I2C Controller Mode and Status Register

This block holds the mode and status state of a byte-oriented I2C controller that can work either as bus master or as slave. A separate bus engine drives one-cycle event strobes into it: START seen, STOP seen, byte finished, arbitration lost, own address matched, address byte received (with its value), and the bit last shifted in. Software reaches the block through an 8-bit write port and a continuously driven read value.

The block keeps the master/slave and transmit/receive bits and applies the rules that drop master mode on its own. It also tracks bus-busy, the arbitration, address and general-call flags, and an active-low interrupt-pending flag. A guard window runs from a detected START to the end of the current byte. A software START request that falls inside this window is refused: the go pulse to the bus engine, which would launch START generation, reset the bit counter and enable SCL output, is withheld, and master mode is dropped. Waveform timing, clock division and shifting belong to the bus engine.

Top module: `i2c_mode_status`

## Requirements
- R1: After reset, read bits 7..1 equal 0b0001000 (only the interrupt flag, b4, is 1), `irqN` is 1 and `startGo` is 0.
- R2: A write loads b7 (master) and b6 (transmit) from the written data; {b7,b6} = 00 slave receive, 01 slave transmit, 10 master receive, 11 master transmit.
- R3: A START strobe sets busy (b5) in the next cycle; a STOP strobe clears busy and the master bit (b7), and STOP wins over a master-bit write in the same cycle.
- R4: An arbitration-lost strobe sets b3 at once, while b7 stays 1 until the byte-finished strobe of that byte, after which b7 reads 0.
- R5: A START request between a START strobe and the next byte-finished or STOP strobe gives no `startGo` pulse and clears b7; a request outside that window gives a one-cycle `startGo` pulse in the next cycle and leaves b7 unchanged.
- R6: The interrupt flag (b4, also `irqN`) goes to 0 in the cycle after a byte-finished strobe and stays 0 until a write with data bit 4 set; writing 0 to bit 4 has no effect.
- R7: When a byte-finished strobe and a write with bit 4 set fall in the same cycle, the flag goes to 0.
- R8: Writes leave b0, b1, b2, b3 and b5 unchanged.
- R9: A START strobe clears b3, b2 and b1.
- R10: An address-match strobe sets b2.
- R11: An address-byte strobe with value 0x00 sets b1 only while b7 is 0; other values, or b7 = 1, leave b1 at 0.
- R12: On a byte-finished strobe b0 takes the value of `lastBit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evStart | input | 1 | START detected on the bus |
| evStop | input | 1 | STOP detected on the bus |
| evByteDone | input | 1 | One byte transfer finished |
| evArbLost | input | 1 | Arbitration lost during the current byte |
| evAddrMatch | input | 1 | Received address equals own address |
| evAddrRecv | input | 1 | Address byte received, value on `addrByte` |
| addrByte | input | 8 | Received address byte |
| lastBit | input | 1 | Last bit shifted in, taken at byte end |
| startReq | input | 1 | Software START request strobe |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Status and mode value |
| irqN | output | 1 | Interrupt pending, active low |
| startGo | output | 1 | Permission pulse to launch a START |

## Verification
Two things can hit the interrupt flag in one cycle: the engine raising it at the end of a byte and software clearing it by writing 1. The bench drives the byte-finished strobe and a write with bit 4 set on the same falling edge and expects the flag at 0 afterwards, so no request is lost. In the same way it drives a STOP strobe together with a write that sets master mode and expects b7 at 0.

// File: rtl/i2c_ms_pkg.sv
package i2c_ms_pkg;
  localparam int STAT_W = 8;
  localparam int B_LRB  = 0;
  localparam int B_GC   = 1;
  localparam int B_AAS  = 2;
  localparam int B_AL   = 3;
  localparam int B_PIN  = 4;
  localparam int B_BB   = 5;
  localparam int B_TRX  = 6;
  localparam int B_MST  = 7;

  typedef struct packed {
    logic busySet;
    logic busyClr;
    logic flagClr;
    logic alSet;
    logic aasSet;
    logic gcSet;
    logic lrbLoad;
    logic irqRaise;
    logic irqAck;
    logic modeWr;
    logic mstClr;
  } strobe_t;
endpackage

// File: rtl/i2c_ms_ctrl.sv
module i2c_ms_ctrl
  import i2c_ms_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] GEN_CALL = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evStart,
  input  logic              evStop,
  input  logic              evByteDone,
  input  logic              evArbLost,
  input  logic              evAddrMatch,
  input  logic              evAddrRecv,
  input  logic [ADDR_W-1:0] addrByte,
  input  logic              startReq,
  input  logic              wrEn,
  input  logic              wrPinBit,
  input  logic              alFlag,
  input  logic              mstFlag,
  output strobe_t           strb,
  output logic              startGo
);
  logic guardOn;
  logic startBlocked;
  logic arbEffective;

  // Window from START until the byte ends (or STOP)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     guardOn <= 1'b0;
    else if (evStart)              guardOn <= 1'b1;
    else if (evByteDone || evStop) guardOn <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) startGo <= 1'b0;
    else       startGo <= startReq && !guardOn;
  end

  assign startBlocked = startReq && guardOn;
  assign arbEffective = alFlag || evArbLost;

  always_comb begin
    strb          = '0;
    strb.busySet  = evStart;
    strb.busyClr  = evStop;
    strb.flagClr  = evStart;
    strb.alSet    = evArbLost;
    strb.aasSet   = evAddrMatch;
    strb.gcSet    = evAddrRecv && (addrByte == GEN_CALL) && !mstFlag;
    strb.lrbLoad  = evByteDone;
    strb.irqRaise = evByteDone;
    strb.irqAck   = wrEn && wrPinBit;
    strb.modeWr   = wrEn;
    strb.mstClr   = evStop || (evByteDone && arbEffective) || startBlocked;
  end

  // R5
  dup_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && guardOn) |=> !startGo);
  // R5
  go_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    startGo |-> $past(startReq));
  // R5
  go_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startGo && !startReq) |=> !startGo);
endmodule

// File: rtl/i2c_ms_datapath.sv
module i2c_ms_datapath
  import i2c_ms_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [STAT_W-1:0] wrData,
  input  logic              lastBit,
  output logic [STAT_W-1:0] status,
  output logic              mstFlag,
  output logic              alFlag,
  output logic              irqN
);
  localparam logic [STAT_W-1:0] MODE_MASK =
    STAT_W'((1 << B_MST) | (1 << B_TRX));

  logic [STAT_W-1:0] modeBits;
  logic mst, trx, bb, pinN, al, aas, gc, lrb;

  assign modeBits = wrData & MODE_MASK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mst  <= 1'b0;
      trx  <= 1'b0;
      bb   <= 1'b0;
      pinN <= 1'b1;
      al   <= 1'b0;
      aas  <= 1'b0;
      gc   <= 1'b0;
      lrb  <= 1'b0;
    end else begin
      if (strb.mstClr)      mst <= 1'b0;
      else if (strb.modeWr) mst <= modeBits[B_MST];
      if (strb.modeWr)      trx <= modeBits[B_TRX];

      if (strb.busyClr)      bb <= 1'b0;
      else if (strb.busySet) bb <= 1'b1;

      if (strb.alSet)        al <= 1'b1;
      else if (strb.flagClr) al <= 1'b0;
      if (strb.aasSet)       aas <= 1'b1;
      else if (strb.flagClr) aas <= 1'b0;
      if (strb.gcSet)        gc <= 1'b1;
      else if (strb.flagClr) gc <= 1'b0;

      if (strb.lrbLoad) lrb <= lastBit;

      if (strb.irqRaise)    pinN <= 1'b0;
      else if (strb.irqAck) pinN <= 1'b1;
    end
  end

  always_comb begin
    status        = '0;
    status[B_LRB] = lrb;
    status[B_GC]  = gc;
    status[B_AAS] = aas;
    status[B_AL]  = al;
    status[B_PIN] = pinN;
    status[B_BB]  = bb;
    status[B_TRX] = trx;
    status[B_MST] = mst;
  end

  assign mstFlag = mst;
  assign alFlag  = al;
  assign irqN    = pinN;

  // R6
  pin_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.irqRaise |=> !irqN);
  // R6
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!irqN && !strb.irqAck) |=> !irqN);
  // R3
  busy_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busySet && !strb.busyClr) |=> status[B_BB]);
  // R3
  mst_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.mstClr |=> !status[B_MST]);
  // R8
  ro_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.modeWr && !(strb.busySet || strb.busyClr || strb.flagClr ||
      strb.alSet || strb.aasSet || strb.gcSet || strb.lrbLoad))
    |=> $stable({status[B_LRB], status[B_GC], status[B_AAS], status[B_AL], status[B_BB]}));
endmodule

// File: rtl/i2c_mode_status.sv
module i2c_mode_status
  import i2c_ms_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evStart,
  input  logic              evStop,
  input  logic              evByteDone,
  input  logic              evArbLost,
  input  logic              evAddrMatch,
  input  logic              evAddrRecv,
  input  logic [ADDR_W-1:0] addrByte,
  input  logic              lastBit,
  input  logic              startReq,
  input  logic              wrEn,
  input  logic [STAT_W-1:0] wrData,
  output logic [STAT_W-1:0] rdData,
  output logic              irqN,
  output logic              startGo
);
  strobe_t strb;
  logic    mstFlag;
  logic    alFlag;

  i2c_ms_ctrl #(.ADDR_W(ADDR_W), .GEN_CALL('0)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .evStart    (evStart),
    .evStop     (evStop),
    .evByteDone (evByteDone),
    .evArbLost  (evArbLost),
    .evAddrMatch(evAddrMatch),
    .evAddrRecv (evAddrRecv),
    .addrByte   (addrByte),
    .startReq   (startReq),
    .wrEn       (wrEn),
    .wrPinBit   (wrData[B_PIN]),
    .alFlag     (alFlag),
    .mstFlag    (mstFlag),
    .strb       (strb),
    .startGo    (startGo)
  );

  i2c_ms_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .lastBit(lastBit),
    .status (rdData),
    .mstFlag(mstFlag),
    .alFlag (alFlag),
    .irqN   (irqN)
  );
endmodule

// File: tb/i2c_mode_status_tb.sv
`timescale 1ns/1ps
module i2c_mode_status_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       evStart = 0, evStop = 0, evByteDone = 0, evArbLost = 0;
  logic       evAddrMatch = 0, evAddrRecv = 0, lastBit = 0, startReq = 0, wrEn = 0;
  logic [7:0] addrByte = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       irqN, startGo;
  int         errors = 0;
  int         checks = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  i2c_mode_status u_dut (
    .clk(clk), .rstN(rstN), .evStart(evStart), .evStop(evStop),
    .evByteDone(evByteDone), .evArbLost(evArbLost), .evAddrMatch(evAddrMatch),
    .evAddrRecv(evAddrRecv), .addrByte(addrByte), .lastBit(lastBit),
    .startReq(startReq), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .irqN(irqN), .startGo(startGo)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wrEn = 1; wrData = d;
    @(negedge clk); wrEn = 0; wrData = '0;
  endtask

  task automatic pulseStart(); @(negedge clk); evStart = 1; @(negedge clk); evStart = 0; endtask
  task automatic pulseStop();  @(negedge clk); evStop = 1;  @(negedge clk); evStop = 0;  endtask
  task automatic pulseDone(input logic b);
    @(negedge clk); evByteDone = 1; lastBit = b;
    @(negedge clk); evByteDone = 0; lastBit = 0;
  endtask

  task automatic t_reset();
    chk("R1 status", rdData & 8'hFE, 8'h10);
    chk("R1 irqN", {7'd0, irqN}, 8'd1);
    chk("R1 startGo", {7'd0, startGo}, 8'd0);
  endtask

  task automatic t_mode();
    wr(8'hC0); chk("R2 master tx", rdData & 8'hC0, 8'hC0);
    wr(8'h40); chk("R2 slave tx", rdData & 8'hC0, 8'h40);
    wr(8'h80); chk("R2 master rx", rdData & 8'hC0, 8'h80);
    wr(8'h00); chk("R2 slave rx", rdData & 8'hC0, 8'h00);
  endtask

  task automatic t_readonly();
    wr(8'hFF); chk("R8 write ones", rdData & 8'hFE, 8'hD0);
    wr(8'h00); chk("R8/R6 write zeros", rdData & 8'hFE, 8'h10);
  endtask

  task automatic t_busy();
    wr(8'h80);
    pulseStart(); chk("R3 busy set", rdData & 8'hA0, 8'hA0);
    pulseStop();  chk("R3 stop clears", rdData & 8'hA0, 8'h00);
  endtask

  task automatic t_arb();
    wr(8'h80);
    pulseStart();
    @(negedge clk); evArbLost = 1; @(negedge clk); evArbLost = 0;
    chk("R4 AL set, mst held", rdData & 8'h88, 8'h88);
    pulseDone(1'b1);
    chk("R4 mst cleared at byte end", rdData & 8'h88, 8'h08);
    chk("R12 lrb one", rdData & 8'h01, 8'h01);
    chk("R6 irq low", {7'd0, irqN}, 8'd0);
    wr(8'h00); chk("R6 write zero ignored", {7'd0, irqN}, 8'd0);
    repeat (3) @(negedge clk);
    chk("R6 irq holds", {7'd0, irqN}, 8'd0);
    wr(8'h10); chk("R6 write one clears", {7'd0, irqN}, 8'd1);
    pulseStart(); chk("R9 start clears AL", rdData & 8'h08, 8'h00);
    pulseStop();
  endtask

  task automatic t_dup();
    wr(8'h80);
    @(negedge clk); startReq = 1; @(negedge clk); startReq = 0;
    chk("R5 free start go", {7'd0, startGo}, 8'd1);
    chk("R5 mst kept", rdData & 8'h80, 8'h80);
    @(negedge clk); chk("R5 go one cycle", {7'd0, startGo}, 8'd0);
    pulseStart();
    @(negedge clk); startReq = 1; @(negedge clk); startReq = 0;
    chk("R5 blocked go", {7'd0, startGo}, 8'd0);
    chk("R5 blocked clears mst", rdData & 8'h80, 8'h00);
    pulseDone(1'b0);
    chk("R12 lrb zero", rdData & 8'h01, 8'h00);
    @(negedge clk); startReq = 1; @(negedge clk); startReq = 0;
    chk("R5 go after byte end", {7'd0, startGo}, 8'd1);
    wr(8'h10);
    pulseStop();
  endtask

  task automatic t_addr();
    wr(8'h00);
    pulseStart();
    @(negedge clk); evAddrMatch = 1; @(negedge clk); evAddrMatch = 0;
    chk("R10 match", rdData & 8'h04, 8'h04);
    @(negedge clk); evAddrRecv = 1; addrByte = 8'h00; @(negedge clk); evAddrRecv = 0;
    chk("R11 general call slave", rdData & 8'h02, 8'h02);
    pulseStart(); chk("R9 start clears AAS/AD0", rdData & 8'h06, 8'h00);
    @(negedge clk); evAddrRecv = 1; addrByte = 8'h42; @(negedge clk); evAddrRecv = 0;
    chk("R11 nonzero addr", rdData & 8'h02, 8'h00);
    wr(8'h80);
    @(negedge clk); evAddrRecv = 1; addrByte = 8'h00; @(negedge clk); evAddrRecv = 0;
    chk("R11 master ignores gc", rdData & 8'h02, 8'h00);
    pulseStop();
  endtask

  task automatic t_collide();
    @(negedge clk); evByteDone = 1; wrEn = 1; wrData = 8'h10;
    @(negedge clk); evByteDone = 0; wrEn = 0; wrData = '0;
    chk("R7 raise beats ack", {7'd0, irqN}, 8'd0);
    wr(8'h10);
    @(negedge clk); evStop = 1; wrEn = 1; wrData = 8'h80;
    @(negedge clk); evStop = 0; wrEn = 0; wrData = '0;
    chk("R3 stop beats mode write", rdData & 8'h80, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_mode();
    t_readonly();
    t_busy();
    t_arb();
    t_dup();
    t_addr();
    t_collide();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule